// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block keeps a 32-bit word of pending interrupt causes and turns it into a request toward the host. It can signal in one of two styles. In line mode it drives a level line. In message mode it emits one-cycle request pulses, which a separate transport turns into messages. Internal sources set cause bits through a mask port. By convention, bit 0 means the arithmetic unit finished and bit 8 means a DMA transfer finished. Software reaches the word over a simple 32-bit register bus: one offset reads it, one offset ORs bits in, and one offset removes bits.

Every set and clear request that arrives in a cycle is merged into a single update of the word, applied at the next rising clock edge. The line and the pulse are registered and change at that same edge. When a set and a clear hit the same bit in one cycle, the set wins. The two styles differ in how they treat a clear. A clear can drop the line once nothing is left pending. In message mode a clear produces nothing at all, while every set request that leaves work pending produces a fresh pulse.

Top module: `irq_status_agg`

## Requirements
- R1: A cycle with `rst` high clears the status word, drives `irq_line_o` low and drives `irq_msg_o` low after the next edge.
- R2: A bus write to offset 0x60 ORs `wr_data_i` into the status word at the next edge. A read with `rd_addr_i` = 0x24 returns the status word combinationally. Any other read address returns 0. Writes to any other offset change nothing.
- R3: A bus write to offset 0x64 clears, at the next edge, every status bit that is 1 in `wr_data_i`, and leaves the other bits unchanged.
- R4: Bits high in `src_set_i` are ORred into the status word at the next edge. This merges with a software set in the same cycle into one update (bit 0 = arithmetic done, bit 8 = DMA done).
- R5: If a bit is both set (by `src_set_i` or offset 0x60) and cleared (offset 0x64) in the same cycle, it is 1 after the edge.
- R6: In line mode (`msg_mode_i` = 0), a set operation leaves `irq_line_o` high after the edge whenever the updated status is nonzero. A set operation is a write to 0x60 or a nonzero `src_set_i`.
- R7: In line mode, `irq_line_o` goes low only after a clear that leaves the whole status word zero. A partial clear keeps it high.
- R8: In message mode (`msg_mode_i` = 1), each cycle with a set operation whose updated status is nonzero produces `irq_msg_o` high for exactly the cycle after that edge. Back-to-back set operations give back-to-back pulses.
- R9: In message mode, `irq_line_o` holds its value through sets and clears, and a clear never produces a pulse.
- R10: In line mode, `irq_msg_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_set_i | input | 32 | Cause bits to set from internal sources |
| msg_mode_i | input | 1 | 1 selects message pulses, 0 selects level line |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 8 | Bus write byte offset |
| wr_data_i | input | 32 | Bus write data |
| rd_addr_i | input | 8 | Bus read byte offset |
| rd_data_o | output | 32 | Bus read data, combinational |
| irq_line_o | output | 1 | Level interrupt line |
| irq_msg_o | output | 1 | One-cycle message request |

## Verification
The embedded properties watch a fixed set of rules on every cycle. Set bits must be present after the edge, even against a clear in the same cycle. Cleared bits that were not also set must be gone. The line may fall only onto an empty word. A pulse appears only in message mode and only with something pending, and the line is frozen while message mode is on. The bench scenarios cover what the properties cannot: the exact merged value of the word, the sweep of every bit position, reads at other offsets, the pulse-per-request count in message mode, and the behaviour when the mode changes while the line is high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ARITH_DONE_BIT = 0;
    localparam int unsigned DMA_DONE_BIT   = 8;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        SIG_LINE = 1'b0,
        SIG_MSG  = 1'b1
    } sig_mode_e;

    typedef struct packed {
        word_t set_m;
        word_t clr_m;
        logic  set_op;
        logic  clr_op;
    } upd_t;

    function automatic word_t apply_upd(word_t cur, upd_t u);
        return (cur & ~u.clr_m) | u.set_m;
    endfunction
endpackage

// File: rtl/irq_wr_decode.sv
module irq_wr_decode
    import irq_agg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] SET_OFF = 'h60,
    parameter logic [ADDR_W-1:0] CLR_OFF = 'h64
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  word_t             src_set,
    output upd_t              upd
);
    logic hit_set;
    logic hit_clr;

    always_comb begin
        hit_set    = wr_en && (wr_addr == SET_OFF);
        hit_clr    = wr_en && (wr_addr == CLR_OFF);
        upd.set_m  = src_set | (hit_set ? wr_data : '0);
        upd.clr_m  = hit_clr ? wr_data : '0;
        upd.set_op = hit_set || (|src_set);
        upd.clr_op = hit_clr;
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  upd_t  upd,
    output word_t status,
    output logic  nxt_nonzero
);
    word_t nxt;

    always_comb begin
        nxt         = apply_upd(status, upd);
        nxt_nonzero = |nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= nxt;
    end

    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (|upd.set_m) |=> ((status & $past(upd.set_m)) == $past(upd.set_m)));

    p_clear_drops_r3: assert property (@(posedge clk) disable iff (rst)
        upd.clr_op |=> ((status & $past(upd.clr_m & ~upd.set_m)) == '0));
endmodule

// File: rtl/irq_signal_gen.sv
module irq_signal_gen
    import irq_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sig_mode_e mode,
    input  logic      set_op,
    input  logic      clr_op,
    input  logic      nxt_nonzero,
    output logic      line,
    output logic      msg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            line <= 1'b0;
            msg  <= 1'b0;
        end else begin
            msg <= (mode == SIG_MSG) && set_op && nxt_nonzero;
            if (mode == SIG_LINE) begin
                if (set_op && nxt_nonzero)
                    line <= 1'b1;
                else if (clr_op && !nxt_nonzero)
                    line <= 1'b0;
            end
        end
    end

    p_line_frozen_msg_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == SIG_MSG) |=> (line == $past(line)));

    p_msg_only_msgmode_r10: assert property (@(posedge clk) disable iff (rst)
        msg |-> ($past(mode) == SIG_MSG));

    p_line_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(line) |-> $past(set_op));
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFF = 'h24,
    parameter logic [ADDR_W-1:0] SET_OFF    = 'h60,
    parameter logic [ADDR_W-1:0] CLR_OFF    = 'h64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       src_set_i,
    input  logic              msg_mode_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [31:0]       wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [31:0]       rd_data_o,
    output logic              irq_line_o,
    output logic              irq_msg_o
);
    upd_t      upd;
    word_t     status;
    logic      nxt_nonzero;
    sig_mode_e mode;

    assign mode = sig_mode_e'(msg_mode_i);

    irq_wr_decode #(
        .ADDR_W (ADDR_W),
        .SET_OFF(SET_OFF),
        .CLR_OFF(CLR_OFF)
    ) u_dec (
        .wr_en  (wr_en_i),
        .wr_addr(wr_addr_i),
        .wr_data(wr_data_i),
        .src_set(src_set_i),
        .upd    (upd)
    );

    irq_status_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .upd        (upd),
        .status     (status),
        .nxt_nonzero(nxt_nonzero)
    );

    irq_signal_gen u_sig (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .set_op     (upd.set_op),
        .clr_op     (upd.clr_op),
        .nxt_nonzero(nxt_nonzero),
        .line       (irq_line_o),
        .msg        (irq_msg_o)
    );

    assign rd_data_o = (rd_addr_i == STATUS_OFF) ? status : '0;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (status == '0 && !irq_line_o && !irq_msg_o));

    p_msg_pending_r8: assert property (@(posedge clk) disable iff (rst)
        irq_msg_o |-> (status != '0));

    p_line_fall_empty_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_line_o) |-> (status == '0));
endmodule

// File: tb/irq_status_agg_tb_top.sv
module irq_status_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;
    localparam logic [7:0] A_STAT = 8'h24;
    localparam logic [7:0] A_SET  = 8'h60;
    localparam logic [7:0] A_CLR  = 8'h64;
    localparam logic [7:0] A_NONE = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src_set = '0;
    logic        msg_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = A_STAT;
    logic [31:0] rd_data;
    logic        irq_line;
    logic        irq_msg;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_stat = '0;
    logic        m_line = 1'b0;
    logic        m_msg = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    irq_status_agg dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_set_i (src_set),
        .msg_mode_i(msg_mode),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_line_o(irq_line),
        .irq_msg_o (irq_msg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cyc, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr;
    endfunction

    // Drive one cycle of stimulus, advance the model, then check all outputs.
    task automatic step(input logic [31:0] src, input bit wr, input logic [7:0] addr,
                        input logic [31:0] data, input bit mode, input string tag);
        logic        set_op;
        logic        clr_op;
        logic [31:0] setm;
        logic [31:0] clrm;
        logic [31:0] nxt;
        @(negedge clk);
        src_set  = src;
        wr_en    = wr;
        wr_addr  = addr;
        wr_data  = data;
        msg_mode = mode;
        set_op = (wr && addr == A_SET) || (src != 0);
        clr_op = wr && addr == A_CLR;
        setm   = src | ((wr && addr == A_SET) ? data : 32'h0);
        clrm   = clr_op ? data : 32'h0;
        nxt    = (m_stat & ~clrm) | setm;
        if (!mode) begin
            m_msg = 1'b0;
            if (set_op && nxt != 0)       m_line = 1'b1;
            else if (clr_op && nxt == 0)  m_line = 1'b0;
        end else begin
            m_msg = set_op && (nxt != 0);
        end
        m_stat = nxt;
        @(posedge clk);
        #1;
        chk({tag, " status"}, rd_data, m_stat);
        chk({tag, " line"}, {31'h0, irq_line}, {31'h0, m_line});
        chk({tag, " msg"}, {31'h0, irq_msg}, {31'h0, m_msg});
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 status", rd_data, 32'h0);
        chk("R1 line", {31'h0, irq_line}, 32'h0);
        chk("R1 msg", {31'h0, irq_msg}, 32'h0);

        // R2 / R3 / R6 / R7: walk every bit through set and clear in line mode
        for (int i = 0; i < 32; i++) begin
            step('0, 1'b1, A_SET, 32'h1 << i, 1'b0, "R2 R6 set bit");
            step('0, 1'b1, A_CLR, 32'h1 << i, 1'b0, "R3 R7 clear bit");
        end

        // R2: write to an unused offset has no effect; other read address gives 0
        step('0, 1'b1, A_SET, 32'h0000_00F0, 1'b0, "R2 seed");
        step('0, 1'b1, A_NONE, 32'hFFFF_FFFF, 1'b0, "R2 unused write");
        @(negedge clk);
        rd_addr = A_NONE;
        #1;
        chk("R2 other read", rd_data, 32'h0);
        rd_addr = A_STAT;

        // R4: internal sources for arithmetic and DMA done, merged with software set
        step(32'h0000_0001, 1'b0, A_NONE, '0, 1'b0, "R4 arith src");
        step(32'h0000_0100, 1'b1, A_SET, 32'h0001_0000, 1'b0, "R4 dma src merged");

        // R7: partial clear keeps line, full clear drops it
        step('0, 1'b1, A_CLR, 32'h0000_0101, 1'b0, "R7 partial clear");
        step('0, 1'b1, A_CLR, 32'hFFFF_FFFF, 1'b0, "R7 full clear");

        // R5: set and clear of same bit in one cycle
        step(32'h0000_0100, 1'b1, A_CLR, 32'h0000_0101, 1'b0, "R5 set wins");
        step('0, 1'b1, A_CLR, 32'hFFFF_FFFF, 1'b0, "R5 cleanup");

        // R10 / R6 / R7: random traffic in line mode
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r;
            logic [31:0] s;
            logic [7:0]  a;
            r = nxt_rand();
            s = (r[3:0] == 4'h0) ? (nxt_rand() & 32'h0000_0101) : 32'h0;
            a = (r[5:4] == 2'd0) ? A_SET : (r[5:4] == 2'd1) ? A_CLR :
                (r[5:4] == 2'd2) ? A_NONE : A_STAT;
            step(s, r[6], a, nxt_rand() & nxt_rand(), 1'b0, "R10 line random");
        end

        // R9: line high, switch to message mode, clear all: line must stay, no pulse
        step('0, 1'b1, A_SET, 32'h0000_0008, 1'b0, "R6 arm line");
        step('0, 1'b1, A_CLR, 32'hFFFF_FFFF, 1'b1, "R9 clear in msg mode");
        step('0, 1'b0, A_NONE, '0, 1'b1, "R9 idle");

        // R8: back-to-back set requests give back-to-back pulses
        step('0, 1'b1, A_SET, 32'h0000_0002, 1'b1, "R8 first pulse");
        step(32'h0000_0001, 1'b0, A_NONE, '0, 1'b1, "R8 second pulse");
        step('0, 1'b1, A_SET, 32'h0, 1'b1, "R8 zero-value set still pending");
        step('0, 1'b0, A_NONE, '0, 1'b1, "R8 pulse ends");
        step('0, 1'b1, A_CLR, 32'h0000_0003, 1'b1, "R9 clear no pulse");
        step('0, 1'b1, A_SET, 32'h0, 1'b1, "R8 empty set no pulse");

        // R8 / R9: random traffic in message mode
        for (int k = 0; k < 300; k++) begin
            logic [31:0] r;
            logic [31:0] s;
            logic [7:0]  a;
            r = nxt_rand();
            s = (r[3:0] == 4'h0) ? (nxt_rand() & 32'h0000_0101) : 32'h0;
            a = (r[5:4] == 2'd0) ? A_SET : (r[5:4] == 2'd1) ? A_CLR :
                (r[5:4] == 2'd2) ? A_NONE : A_STAT;
            step(s, r[6], a, nxt_rand() & nxt_rand(), 1'b1, "R8 R9 msg random");
        end

        // R1: reset in the middle of activity
        step('0, 1'b1, A_SET, 32'hA5A5_0000, 1'b0, "R6 before reset");
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        src_set = '0;
        @(posedge clk);
        #1;
        chk("R1 status after reset", rd_data, 32'h0);
        chk("R1 line after reset", {31'h0, irq_line}, 32'h0);
        chk("R1 msg after reset", {31'h0, irq_msg}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule